// File: doc/BRIEF.md
# Quadratic-Interval Sampling Phase Detector

This block is the phase detector of an all-digital clock and data recovery loop. A serial NRZ input is sampled sixteen times per bit period, once on each of sixteen equally spaced phases. Each phase is modelled as a one-cycle enable strobe in a single clock domain. When the last phase of a period has been sampled, the detector compares neighbouring samples to find the first data edge in the window. It then classifies the position of that edge into one of seven regions.

The regions are mirrored about a two-slot centre region. Their widths are 4, 2, 1, 2, 1, 2, 4 slots, counted from the start of the window. An edge early in the window means the recovered clock is late, so it raises a down indication with weight 4, 2 or 1. An edge late in the window raises an up indication with weight 1, 2 or 4. An edge in the centre raises the lock indication. Because the weights grow with distance from the centre, the gain is quadratic, and a linear detector would need twice as many phases for the same gain. The loop filter downstream combines the weighted indications.

Top module: `qspd_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `up_o`, `dn_o` and `lock_o` are all cleared to zero on that edge.
- R2: A first edge in slots 0 to 3 gives `dn_o` = 3'b100 (weight 4), with `up_o` and `lock_o` at zero. Slot k is the position between the sample on phase k-1 and the sample on phase k.
- R3: A first edge in slot 4 or 5 gives `dn_o` = 3'b010 (weight 2) and nothing else.
- R4: A first edge in slot 6 gives `dn_o` = 3'b001 (weight 1) and nothing else.
- R5: A first edge in slot 7 or 8 gives `lock_o` = 1, with `up_o` and `dn_o` at zero.
- R6: A first edge in slot 9 gives `up_o` = 3'b001 (weight 1) and nothing else.
- R7: A first edge in slot 10 or 11 gives `up_o` = 3'b010 (weight 2) and nothing else.
- R8: A first edge in slot 12 to 15 gives `up_o` = 3'b100 (weight 4) and nothing else.
- R9: A period with no edge drives all seven outputs to zero.
- R10: The outputs change only on the rising edge that samples `phase_stb[15]`. They then hold until the next such edge, which is one bit period. Bit i of `phase_stb` is the strobe of phase i, and at most one strobe is high per cycle.
- R11: When a period holds more than one edge, only the earliest slot is classified.
- R12: Slot 0 compares the phase-0 sample with the phase-15 sample of the previous period. The first period after reset has no previous sample, so a slot-0 difference in that period is ignored.
- R13: At most one of the seven output bits is high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial NRZ data |
| phase_stb | input | 16 | One-cycle sample strobe per phase, bit i for phase i |
| up_o | output | 3 | Late-edge indications, bit 0 weight 1, bit 1 weight 2, bit 2 weight 4 |
| dn_o | output | 3 | Early-edge indications, bit 2 weight 4, bit 1 weight 2, bit 0 weight 1 |
| lock_o | output | 1 | Edge in the centre region |

## Verification
Every classification is due on the same rising edge that samples the phase-15 strobe. The bench drives `din` and the strobes on falling edges and lowers the strobe after phase 15. It then reads the result on the very next falling edge, half a cycle after the update. For the hold rule, the bench reads the outputs after each strobe of the following period and expects the old value each time. It then expects the new value half a cycle after that period's phase-15 edge.

// File: rtl/qspd_pkg.sv
package qspd_pkg;
    localparam int NUM_PHASES = 16;
    localparam int IDX_W      = $clog2(NUM_PHASES);

    // Region widths in slots, mirrored about the centre
    localparam int W_EDGE = 4;
    localparam int W_SIDE = 2;
    localparam int W_NEAR = 1;
    localparam int W_CTR  = 2;

    // First slot of each region, counted from the window start
    localparam int B_DN2 = W_EDGE;
    localparam int B_DN1 = B_DN2 + W_SIDE;
    localparam int B_LC  = B_DN1 + W_NEAR;
    localparam int B_UP1 = B_LC + W_CTR;
    localparam int B_UP2 = B_UP1 + W_NEAR;
    localparam int B_UP4 = B_UP2 + W_SIDE;

    typedef struct packed {
        logic [2:0] up;
        logic       lock;
        logic [2:0] dn;
    } pd_out_t;
endpackage

// File: rtl/qspd_sampler.sv
module qspd_sampler #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din,
    input  logic [N-1:0] stb,
    output logic [N-1:0] win_o,
    output logic         ref_o,
    output logic         ref_ok_o,
    output logic         eval_o
);
    typedef struct packed {
        logic [N-2:0] smp;
        logic         refb;
        logic         primed;
    } smp_state_t;

    smp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N - 1; i++) begin
            if (stb[i]) st_d.smp[i] = din;
        end
        if (stb[N-1]) begin
            st_d.refb   = din;
            st_d.primed = 1'b1;
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign win_o    = {din, st_q.smp};
    assign ref_o    = st_q.refb;
    assign ref_ok_o = st_q.primed;
    assign eval_o   = stb[N-1];
endmodule

// File: rtl/qspd_locator.sv
module qspd_locator #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     win,
    input  logic             refb,
    input  logic             ref_ok,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [N-1:0] edge_v;

    assign edge_v[0] = (win[0] ^ refb) & ref_ok;

    generate
        for (genvar k = 1; k < N; k++) begin : g_edge
            assign edge_v[k] = win[k] ^ win[k-1];
        end
    endgenerate

    // Scanning downward lets the earliest edge overwrite later ones
    always_comb begin
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (edge_v[k]) idx_o = IDX_W'(k);
        end
    end

    assign found_o = |edge_v;
endmodule

// File: rtl/qspd_region_map.sv
module qspd_region_map
    import qspd_pkg::*;
(
    input  logic             found,
    input  logic [IDX_W-1:0] idx,
    output pd_out_t          res_o
);
    int slot;

    always_comb begin
        slot  = int'(idx);
        res_o = '0;
        if (found) begin
            if (slot < B_DN2)      res_o.dn   = 3'b100;
            else if (slot < B_DN1) res_o.dn   = 3'b010;
            else if (slot < B_LC)  res_o.dn   = 3'b001;
            else if (slot < B_UP1) res_o.lock = 1'b1;
            else if (slot < B_UP2) res_o.up   = 3'b001;
            else if (slot < B_UP4) res_o.up   = 3'b010;
            else                   res_o.up   = 3'b100;
        end
    end
endmodule

// File: rtl/qspd_top.sv
module qspd_top
    import qspd_pkg::*;
#(
    parameter int N_PH = NUM_PHASES
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    input  logic [N_PH-1:0] phase_stb,
    output logic [2:0]      up_o,
    output logic [2:0]      dn_o,
    output logic            lock_o
);
    localparam int IW = $clog2(N_PH);

    logic [N_PH-1:0] win_w;
    logic            ref_w, ref_ok_w, eval_w, found_w;
    logic [IW-1:0]   idx_w;
    pd_out_t         map_w;
    pd_out_t         out_d, out_q;

    qspd_sampler #(.N(N_PH)) i_sampler (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .stb      (phase_stb),
        .win_o    (win_w),
        .ref_o    (ref_w),
        .ref_ok_o (ref_ok_w),
        .eval_o   (eval_w)
    );

    qspd_locator #(.N(N_PH), .IDX_W(IW)) i_locator (
        .win     (win_w),
        .refb    (ref_w),
        .ref_ok  (ref_ok_w),
        .found_o (found_w),
        .idx_o   (idx_w)
    );

    qspd_region_map i_map (
        .found (found_w),
        .idx   (idx_w),
        .res_o (map_w)
    );

    always_comb begin
        out_d = out_q;
        if (eval_w) out_d = map_w;
        if (rst)    out_d = '0;
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign up_o   = out_q.up;
    assign dn_o   = out_q.dn;
    assign lock_o = out_q.lock;
endmodule

// File: rtl/qspd_checker.sv
module qspd_checker
    import qspd_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_PHASES-1:0] phase_stb,
    input logic [2:0]            up_o,
    input logic [2:0]            dn_o,
    input logic                  lock_o,
    input logic                  eval_w,
    input logic                  found_w,
    input logic [IDX_W-1:0]      idx_w
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (up_o == 3'b000 && dn_o == 3'b000 && !lock_o));

    // R13
    single_out_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({up_o, lock_o, dn_o}));

    // R10
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(phase_stb[NUM_PHASES-1]) |-> $stable({up_o, lock_o, dn_o}));

    // R10
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_stb));

    // R9
    quiet_period_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_w && !found_w) |=> (up_o == 3'b000 && dn_o == 3'b000 && !lock_o));

    // R5
    centre_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (eval_w && found_w && int'(idx_w) >= B_LC && int'(idx_w) < B_UP1) |=> lock_o);
endmodule

bind qspd_top qspd_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .phase_stb (phase_stb),
    .up_o      (up_o),
    .dn_o      (dn_o),
    .lock_o    (lock_o),
    .eval_w    (eval_w),
    .found_w   (found_w),
    .idx_w     (idx_w)
);

// File: tb/test_qspd_top.sv
module test_qspd_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        din = 1'b0;
    logic [15:0] phase_stb = '0;
    logic [2:0]  up_o, dn_o;
    logic        lock_o;

    int   checks = 0;
    int   errors = 0;
    logic last_bit = 1'b0;

    always #2.5 clk = ~clk;

    qspd_top i_qspd_top (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .phase_stb (phase_stb),
        .up_o      (up_o),
        .dn_o      (dn_o),
        .lock_o    (lock_o)
    );

    function automatic logic [6:0] exp_for(int k);
        if (k <= 3)  return 7'b000_0_100;
        if (k <= 5)  return 7'b000_0_010;
        if (k == 6)  return 7'b000_0_001;
        if (k <= 8)  return 7'b000_1_000;
        if (k == 9)  return 7'b001_0_000;
        if (k <= 11) return 7'b010_0_000;
        return 7'b100_0_000;
    endfunction

    function automatic string req_for(int k);
        if (k <= 3)  return "R2";
        if (k <= 5)  return "R3";
        if (k == 6)  return "R4";
        if (k <= 8)  return "R5";
        if (k == 9)  return "R6";
        if (k <= 11) return "R7";
        return "R8";
    endfunction

    function automatic logic [15:0] step_at(int k, logic lb);
        logic [15:0] p;
        for (int i = 0; i < 16; i++) p[i] = (i < k) ? lb : ~lb;
        return p;
    endfunction

    task automatic check(string req, logic [6:0] exp);
        logic [6:0] act;
        act = {up_o, lock_o, dn_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: outputs {up,lock,dn} = %b, expected %b", req, act, exp);
        end
    endtask

    // Drives one bit period; with hold set, checks the old value after each strobe
    task automatic run_period(logic [15:0] pat, bit hold, logic [6:0] old);
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            din       = pat[k];
            phase_stb = 16'(1) << k;
            if (hold) check("R10", old);
        end
        @(negedge clk);
        phase_stb = '0;
        last_bit  = pat[15];
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", 7'b0);
        rst = 1'b0;
    endtask

    task automatic t_prime();
        run_period(16'hFFFF, 1'b0, 7'b0);
        check("R12", 7'b0);
        run_period(16'h0000, 1'b0, 7'b0);
        check("R12", 7'b000_0_100);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 16; k++) begin
            run_period(step_at(k, last_bit), 1'b0, 7'b0);
            check(req_for(k), exp_for(k));
        end
    endtask

    task automatic t_none();
        run_period(step_at(13, last_bit), 1'b0, 7'b0);
        check("R8", 7'b100_0_000);
        run_period({16{last_bit}}, 1'b0, 7'b0);
        check("R9", 7'b0);
    endtask

    task automatic t_multi();
        logic [15:0] p;
        for (int i = 0; i < 16; i++) p[i] = (i >= 5 && i < 12) ? ~last_bit : last_bit;
        run_period(p, 1'b0, 7'b0);
        check("R11", 7'b000_0_010);
        for (int i = 0; i < 16; i++) p[i] = (i == 8) ? ~last_bit : last_bit;
        run_period(p, 1'b0, 7'b0);
        check("R11", 7'b000_1_000);
    endtask

    task automatic t_hold();
        run_period(step_at(10, last_bit), 1'b0, 7'b0);
        check("R7", 7'b010_0_000);
        run_period({16{last_bit}}, 1'b1, 7'b010_0_000);
        check("R10", 7'b0);
    endtask

    task automatic t_reset_mid();
        run_period(step_at(2, last_bit), 1'b0, 7'b0);
        check("R2", 7'b000_0_100);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1", 7'b0);
        rst = 1'b0;
        run_period({16{~last_bit}}, 1'b0, 7'b0);
        check("R12", 7'b0);
    endtask

    initial begin
        t_reset();
        t_prime();
        t_sweep();
        t_none();
        t_multi();
        t_hold();
        t_reset_mid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual timeout, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule